// File: doc/BRIEF.md
# Framed Image Stream Write Port

This block takes a stream of image words from surrounding logic and holds them in a small FIFO until a consumer drains them. A line boundary or a frame boundary travels as a marker word of its own in the same FIFO, with no pixel content. It does not travel as a flag attached to a pixel. On the read side every word carries a 2-bit tag that says what it is, and words leave under a valid/ready handshake. Both sides run on one clock.

Next to the stream, the port carries a small software-written register set. It has a number of runtime parameters, each with a data output and a one-cycle update strobe. It also has a format index that selects one of the image formats the port supports, and a control word that drives a process reset and a process enable toward the attached logic. The FIFO raises a full flag and reports its fill level. A write made while the FIFO is full is dropped and sets a sticky overflow flag. A frame end that arrives without a line end sets a sticky protocol-error flag.

Top module: `img_write_port`

## Requirements
- R1: A write is accepted on any rising edge where `wr_valid` is high and `full` is low. Accepted words reach the read side in write order, and `fill_cnt` rises by one when nothing is popped in the same cycle.
- R2: A write with `wr_eol` and `wr_eof` both low is a pixel word. It is read out with tag 2'b00 and with `rd_data` equal to the written data.
- R3: A write with `wr_eol` high and `wr_eof` low is read out with tag 2'b01 (line end). A write with both high is read out with tag 2'b11 (frame end). Tag 2'b10 never appears.
- R4: `fill_cnt` equals the number of words held and is $clog2(DEPTH+1) bits wide. `full` is high exactly when DEPTH words are held.
- R5: A write while `full` is high is dropped, and `overflow` goes high one cycle later and stays high until reset.
- R6: Every marker word (tag 01 or 11) is read out with `rd_data` equal to zero, whatever data was written with it.
- R7: A write with `wr_eof` high and `wr_eol` low sets the sticky `proto_err` one cycle later. If accepted, the word is stored as a line end (tag 01).
- R8: A software write (`cfg_we` high) with `cfg_sel` = i < NUM_PAR loads parameter i, bits [i*PAR_W +: PAR_W] of `par_data`, from `cfg_wdata` on that edge. `par_upd[i]` is high for exactly the following cycle. A strobe repeats only for back-to-back writes.
- R9: A software write with `cfg_sel` = NUM_PAR loads `fmt_id` when `cfg_wdata` < NUM_FMT. A larger value is ignored and `fmt_id` keeps its value.
- R10: A software write with `cfg_sel` = NUM_PAR+1 loads `proc_reset` from `cfg_wdata[0]` and `proc_enable` from `cfg_wdata[1]`.
- R11: A pop happens on a rising edge where `rd_valid` and `rd_ready` are both high. A simultaneous accepted write and pop leave `fill_cnt` unchanged.
- R12: Synchronous reset `rst` empties the FIFO. It clears `fill_cnt`, `overflow`, `proto_err`, every parameter, every strobe, `fmt_id`, `proc_reset` and `proc_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data (pixel content when not a marker) |
| wr_eol | input | 1 | Word is a line-end marker |
| wr_eof | input | 1 | Word is a frame-end marker (legal only with wr_eol) |
| full | output | 1 | FIFO holds DEPTH words |
| fill_cnt | output | $clog2(DEPTH+1) | Words held |
| overflow | output | 1 | Sticky: a write was dropped |
| proto_err | output | 1 | Sticky: frame end without line end |
| rd_valid | output | 1 | A word is available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Head word data, zero for markers |
| rd_tag | output | 2 | 00 pixel, 01 line end, 11 frame end |
| cfg_we | input | 1 | Software register write |
| cfg_sel | input | $clog2(NUM_PAR+2) | Register select |
| cfg_wdata | input | PAR_W | Software write data |
| par_data | output | NUM_PAR*PAR_W | Parameter values, parameter i at [i*PAR_W +: PAR_W] |
| par_upd | output | NUM_PAR | One-cycle update strobe per parameter |
| fmt_id | output | $clog2(NUM_FMT) (min 1) | Selected format index |
| proc_reset | output | 1 | Process reset toward attached logic |
| proc_enable | output | 1 | Process enable toward attached logic |

## Verification
The properties assume that the inputs change only between clock edges. They also assume that `cfg_sel` never exceeds NUM_PAR+1. No property requires `wr_eof` to come with `wr_eol`: that violation is legal input, and it is what the error flag reports. The random stimulus draws `cfg_sel` only from the four valid selects, including format values at and above NUM_FMT. It mixes frame-end-without-line-end writes in at a low rate and varies `rd_ready` so that the FIFO repeatedly fills up, overflows and drains.

// File: rtl/img_write_port.sv
module img_write_port #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int NUM_FMT = 3,
  parameter int NUM_PAR = 2,
  parameter int PAR_W   = 12,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FID_W  = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1,
  localparam int SEL_W  = $clog2(NUM_PAR + 2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_eol,
  input  logic                     wr_eof,
  output logic                     full,
  output logic [CNT_W-1:0]         fill_cnt,
  output logic                     overflow,
  output logic                     proto_err,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [DATA_W-1:0]        rd_data,
  output logic [1:0]               rd_tag,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [PAR_W-1:0]         cfg_wdata,
  output logic [NUM_PAR*PAR_W-1:0] par_data,
  output logic [NUM_PAR-1:0]       par_upd,
  output logic [FID_W-1:0]         fmt_id,
  output logic                     proc_reset,
  output logic                     proc_enable
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WW = DATA_W + 2;

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop, marker;
  logic [1:0]    wtag;

  assign full     = (fill_cnt == CNT_W'(DEPTH));
  assign rd_valid = (fill_cnt != '0);
  assign push     = wr_valid && !full;
  assign pop      = rd_valid && rd_ready;
  assign marker   = wr_eol || wr_eof;
  assign wtag     = {wr_eol && wr_eof, marker};
  assign rd_tag   = mem[rptr][WW-1 -: 2];
  assign rd_data  = mem[rptr][DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wtag, marker ? DATA_W'(0) : wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      fill_cnt  <= '0;
      overflow  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      fill_cnt <= fill_cnt + 1'b1;
      else if (pop && !push) fill_cnt <= fill_cnt - 1'b1;
      if (wr_valid && full)             overflow  <= 1'b1;
      if (wr_valid && wr_eof && !wr_eol) proto_err <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PAR; i++) begin : g_par
    always_ff @(posedge clk) begin
      if (rst) begin
        par_data[i*PAR_W +: PAR_W] <= '0;
        par_upd[i]                 <= 1'b0;
      end else begin
        par_upd[i] <= cfg_we && (cfg_sel == SEL_W'(i));
        if (cfg_we && (cfg_sel == SEL_W'(i))) par_data[i*PAR_W +: PAR_W] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_id      <= '0;
      proc_reset  <= 1'b0;
      proc_enable <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(NUM_PAR) && cfg_wdata < PAR_W'(NUM_FMT))
        fmt_id <= cfg_wdata[FID_W-1:0];
      if (cfg_sel == SEL_W'(NUM_PAR + 1)) begin
        proc_reset  <= cfg_wdata[0];
        proc_enable <= cfg_wdata[1];
      end
    end
  end
endmodule

// File: rtl/img_write_port_chk.sv
module img_write_port_chk #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int NUM_FMT = 3,
  parameter int NUM_PAR = 2,
  parameter int PAR_W   = 12,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FID_W  = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1,
  localparam int SEL_W  = $clog2(NUM_PAR + 2)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_valid,
  input logic                     wr_eol,
  input logic                     wr_eof,
  input logic                     full,
  input logic [CNT_W-1:0]         fill_cnt,
  input logic                     overflow,
  input logic                     proto_err,
  input logic                     rd_valid,
  input logic                     rd_ready,
  input logic [DATA_W-1:0]        rd_data,
  input logic [1:0]               rd_tag,
  input logic                     cfg_we,
  input logic [SEL_W-1:0]         cfg_sel,
  input logic [PAR_W-1:0]         cfg_wdata,
  input logic [NUM_PAR*PAR_W-1:0] par_data,
  input logic [NUM_PAR-1:0]       par_upd,
  input logic [FID_W-1:0]         fmt_id,
  input logic                     proc_reset,
  input logic                     proc_enable
);
  a_r1_count_up: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !full && !(rd_valid && rd_ready)) |=> fill_cnt == $past(fill_cnt) + 1'b1);
  a_r3_tag_legal: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_tag != 2'b10);
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));
  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full) |=> overflow);
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r6_marker_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_tag != 2'b00) |-> rd_data == '0);
  a_r7_proto_err: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_eof && !wr_eol) |=> proto_err);
  a_r9_fid_range: assert property (@(posedge clk) disable iff (rst)
    fmt_id < FID_W'(NUM_FMT));
  a_r10_ctrl: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_W'(NUM_PAR + 1)) |=>
      (proc_reset == $past(cfg_wdata[0]) && proc_enable == $past(cfg_wdata[1])));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !full && rd_valid && rd_ready) |=> $stable(fill_cnt));

  for (genvar i = 0; i < NUM_PAR; i++) begin : g_upd
    a_r8_upd_pulse: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel == SEL_W'(i)) |=>
        (par_upd[i] && par_data[i*PAR_W +: PAR_W] == $past(cfg_wdata)));
    a_r8_upd_quiet: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_sel == SEL_W'(i)) |=> !par_upd[i]);
  end
endmodule

bind img_write_port img_write_port_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_FMT(NUM_FMT), .NUM_PAR(NUM_PAR), .PAR_W(PAR_W)
) i_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_eol(wr_eol), .wr_eof(wr_eof),
  .full(full), .fill_cnt(fill_cnt), .overflow(overflow), .proto_err(proto_err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_tag(rd_tag),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .par_data(par_data),
  .par_upd(par_upd), .fmt_id(fmt_id), .proc_reset(proc_reset), .proc_enable(proc_enable)
);

// File: tb/test_img_write_port.sv
module test_img_write_port;
  localparam int DW = 16, DEPTH = 8, NF = 3, NP = 2, PW = 12;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_eol = 0, wr_eof = 0, rd_ready = 0, cfg_we = 0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] cfg_sel = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic full, overflow, proto_err, rd_valid, proc_reset, proc_enable;
  logic [3:0] fill_cnt;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_tag, fmt_id;
  logic [NP*PW-1:0] par_data;
  logic [NP-1:0] par_upd;

  img_write_port #(.DATA_W(DW), .DEPTH(DEPTH), .NUM_FMT(NF), .NUM_PAR(NP), .PAR_W(PW)) i_img_write_port (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_eol(wr_eol), .wr_eof(wr_eof),
    .full(full), .fill_cnt(fill_cnt), .overflow(overflow), .proto_err(proto_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_tag(rd_tag),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .par_data(par_data),
    .par_upd(par_upd), .fmt_id(fmt_id), .proc_reset(proc_reset), .proc_enable(proc_enable));

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [DW+1:0] q[$];
  bit ovf_m, perr_m, prst_m, pen_m;
  logic [PW-1:0] par_m [NP];
  logic [NP-1:0] upd_m;
  logic [1:0] fmt_m;

  function automatic logic [1:0] tag_of(input bit eol, input bit eof);
    if (eol && eof) return 2'b11;
    if (eol || eof) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4", "fill_cnt", 32'(fill_cnt), 32'(q.size()));
    chk("R4", "full", 32'(full), 32'(q.size() == DEPTH));
    chk("R11", "rd_valid", 32'(rd_valid), 32'(q.size() != 0));
    if (q.size() != 0) begin
      chk(q[0][DW+1:DW] == 2'b00 ? "R2" : "R3", "rd_tag", 32'(rd_tag), 32'(q[0][DW+1:DW]));
      chk(q[0][DW+1:DW] == 2'b00 ? "R1" : "R6", "rd_data", 32'(rd_data), 32'(q[0][DW-1:0]));
    end
    chk("R5", "overflow", 32'(overflow), 32'(ovf_m));
    chk("R7", "proto_err", 32'(proto_err), 32'(perr_m));
    for (int i = 0; i < NP; i++) chk("R8", "par_data", 32'(par_data[i*PW +: PW]), 32'(par_m[i]));
    chk("R8", "par_upd", 32'(par_upd), 32'(upd_m));
    chk("R9", "fmt_id", 32'(fmt_id), 32'(fmt_m));
    chk("R10", "proc_ctrl", 32'({proc_enable, proc_reset}), 32'({pen_m, prst_m}));
  endtask

  task automatic model_clear();
    q.delete();
    ovf_m = 0; perr_m = 0; prst_m = 0; pen_m = 0; fmt_m = 0; upd_m = 0;
    for (int i = 0; i < NP; i++) par_m[i] = '0;
  endtask

  task automatic step(input bit wv, input logic [DW-1:0] d, input bit eol, input bit eof,
                      input bit rr, input bit we, input logic [1:0] sel, input logic [PW-1:0] wd);
    bit pop, push;
    check_all();
    wr_valid = wv; wr_data = d; wr_eol = eol; wr_eof = eof; rd_ready = rr;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    pop = (q.size() != 0) && rr;
    push = wv && (q.size() < DEPTH);
    if (wv && q.size() == DEPTH) ovf_m = 1;
    if (wv && eof && !eol) perr_m = 1;
    if (pop) void'(q.pop_front());
    if (push) q.push_back({tag_of(eol, eof), (eol || eof) ? DW'(0) : d});
    upd_m = '0;
    if (we) begin
      if (sel < NP) begin par_m[sel] = wd; upd_m[sel] = 1'b1; end
      else if (sel == NP) begin if (wd < NF) fmt_m = wd[1:0]; end
      else begin prst_m = wd[0]; pen_m = wd[1]; end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; wr_valid = 0; rd_ready = 0; cfg_we = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    model_clear();
    @(negedge clk);
    do_reset();
    check_all();                                       // R12 reset state
    // R1 R2 R3 R4 R5 R6: fill past depth with a frame's worth of words, no reads
    step(1, 16'h1111, 0, 0, 0, 0, 0, 0);
    step(1, 16'h2222, 0, 0, 0, 0, 0, 0);
    step(1, 16'hBEEF, 1, 0, 0, 0, 0, 0);
    step(1, 16'h3333, 0, 0, 0, 0, 0, 0);
    step(1, 16'hCAFE, 1, 1, 0, 0, 0, 0);
    step(1, 16'h4444, 0, 0, 0, 0, 0, 0);
    step(1, 16'h5555, 0, 0, 0, 0, 0, 0);
    step(1, 16'h6666, 0, 0, 0, 0, 0, 0);
    step(1, 16'h7777, 0, 0, 0, 0, 0, 0);               // R5 dropped while full
    step(0, 0, 0, 0, 1, 0, 0, 0);                      // R11 pop one
    step(1, 16'h8888, 0, 0, 1, 0, 0, 0);               // R11 push and pop together
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    // R7 frame end without line end
    step(1, 16'hABCD, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    // R8 R9 R10 register writes
    step(0, 0, 0, 0, 0, 1, 0, 12'h5A5);
    step(0, 0, 0, 0, 0, 1, 1, 12'h123);
    step(0, 0, 0, 0, 0, 1, 1, 12'h321);
    step(0, 0, 0, 0, 0, 1, 2, 12'd2);
    step(0, 0, 0, 0, 0, 1, 2, 12'd3);                  // R9 out of range ignored
    step(0, 0, 0, 0, 0, 1, 3, 12'h3);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R12 reset mid-run with content and flags set
    step(1, 16'h0F0F, 0, 0, 0, 0, 0, 0);
    do_reset();
    check_all();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      bit eol = (r < 15);
      bit eof = (r < 5) || (r == 99);
      step(bit'($urandom_range(0, 99) < 60), 16'($urandom), eol, eof,
           bit'($urandom_range(0, 99) < ((n / 500) % 2 ? 70 : 35)),
           bit'($urandom_range(0, 99) < 20), 2'($urandom_range(0, 3)), 12'($urandom_range(0, 4)));
      if (n == 2000) do_reset();
    end
    check_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule